// File: doc/BRIEF.md
# Buffered Asynchronous Serial Receiver

This block takes an idle-high serial line and turns it into characters. The line is sampled on a baud tick input. The sampling divisor is 16 ticks per bit, or 8 ticks per bit when the double-speed option is on. A falling edge starts a frame. The frame is kept only if the line is still low at the middle of the start bit. Every later bit is decided by a two-of-three vote of the samples around the bit centre. Characters can be 5 to 9 bits long, with an optional even or odd parity bit and one stop bit.

Finished characters go into a two-entry buffer. Each entry keeps its own frame-error and parity-error results. A third finished character waits in a hold register until a read frees a slot. If a fourth start bit is confirmed while that hold register is still occupied, the held character is lost and an overrun mark is placed on the oldest character. A multi-drop filter can throw away frames whose address indicator is clear.

A small register port gives access to the data, status, control and format registers. Three interrupt requests are gated by their enables and by a global enable input: character ready, transmit done and transmit empty. The last two take their status from external flag inputs.

Top module: `serial_rx_buf`

## Requirements
- R1: The format register at address 3 sets the character length: code FMT[2:0] = 0..4 gives 5..9 bits, received least significant bit first. A read of address 0 returns bits 7:0 of the oldest character and removes it. STAT (address 1) bit 7 is 1 while the buffer holds a character, and STAT bit 6 shows that character's ninth bit.
- R2: Up to two finished characters are held in arrival order. A third one waits and moves in once a read frees a slot. A read that falls in the same cycle as a character finishing loses no data.
- R3: FMT[4] enables a parity bit and FMT[5] = 1 selects odd parity instead of even. STAT[2] shows a parity mismatch for the oldest character, and only if parity was enabled for it.
- R4: STAT[4] is 1 when the oldest character's stop bit was sampled as 0, and 0 when it was sampled as 1.
- R5: The error flags belong to each character. After the oldest character is read, they show the results of the next character.
- R6: Overrun is detected when a start bit is confirmed while the buffer is full and a third character is waiting. The waiting character is then dropped, both buffered characters are kept, and STAT[3] becomes 1 on the oldest character.
- R7: STAT[1] = 1 makes the receiver use 8 baud ticks per bit instead of 16.
- R8: A low pulse on the line that is gone by the middle of the start bit starts no character. A one-tick glitch inside a data bit is outvoted by the other two centre samples.
- R9: With STAT[0] = 1, a frame is dropped unless its address indicator is 1. The indicator is the ninth data bit for 9-bit characters and the stop bit otherwise.
- R10: CTRL (address 2) bit 4 enables the receiver. Clearing it empties the buffer and clears all error flags, and the line is ignored while it is 0.
- R11: irq_rxc, irq_txc and irq_udre are each 1 only when gie is 1, their enable is 1 (CTRL bits 7, 6 and 5) and their flag is 1. The flags are STAT[7], tx_done_i and tx_empty_i.
- R12: Writes to STAT change only bits 1:0. Writing 1s to bits 4:2 leaves the error flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high |
| baud_tick | input | 1 | One-cycle sample strobe |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops at address 0) |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| gie | input | 1 | Global interrupt enable |
| tx_done_i | input | 1 | Transmit-done flag from a transmitter |
| tx_empty_i | input | 1 | Transmit-register-empty flag from a transmitter |
| irq_rxc | output | 1 | Character-ready request |
| irq_txc | output | 1 | Transmit-done request |
| irq_udre | output | 1 | Transmit-empty request |

## Verification
Two events can fall in the same cycle: a read that pops the oldest character, and the stop bit of an incoming character being resolved, which pushes it. To provoke this, one character is preloaded. While a second character arrives, the data register is read at every cycle offset across the whole stop bit, so that one offset hits the push exactly. In each case the popped value must be the preloaded character, the second character must then be read back unchanged, and the buffer must be empty afterwards. Overrun is provoked the same way, by letting a start bit arrive while both buffer slots and the hold register are full.

// File: rtl/serial_rx_buf.sv
module serial_rx_buf (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       baud_tick,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       gie,
  input  logic       tx_done_i,
  input  logic       tx_empty_i,
  output logic       irq_rxc,
  output logic       irq_txc,
  output logic       irq_udre
);
  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP} st_t;
  st_t st;
  logic dbl, mpm, ie_rxc, ie_txc, ie_udre, rx_en, pen, podd;
  logic [2:0] size;
  logic [3:0] tcnt, bitn, nbits, half, last;
  logic v0, v1, vote, xacc, pbit;
  logic [8:0] sh, dat;
  logic [11:0] q0, q1, hold, newe, n0, n1, nhold;
  logic [1:0] cnt, ncnt;
  logic hold_v, nhv, rxc, pop, done, push, start_ok, ovr_set, ind;

  assign half     = dbl ? 4'd4 : 4'd8;
  assign last     = dbl ? 4'd7 : 4'd15;
  assign nbits    = (size > 3'd4) ? 4'd9 : {1'b0, size} + 4'd5;
  assign vote     = (v0 & v1) | (v0 & rxd) | (v1 & rxd);
  assign rxc      = cnt != 2'd0;
  assign pop      = rd_en && addr == 2'd0 && rxc;
  assign done     = rx_en && baud_tick && st == STOP && tcnt == half + 4'd1;
  assign dat      = sh >> (4'd9 - nbits);
  assign ind      = (nbits == 4'd9) ? dat[8] : vote;
  assign push     = done && (!mpm || ind);
  assign newe     = {1'b0, pen & (xacc ^ pbit ^ podd), ~vote, dat};
  assign start_ok = rx_en && baud_tick && st == START && tcnt == half && !rxd;
  assign ovr_set  = start_ok && hold_v && cnt == 2'd2 && !pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; tcnt <= '0; bitn <= '0; v0 <= 1'b1; v1 <= 1'b1;
      sh <= '0; xacc <= 1'b0; pbit <= 1'b0;
    end else if (!rx_en) begin
      st <= IDLE;
    end else if (baud_tick) begin
      if (st != IDLE) tcnt <= tcnt + 4'd1;
      if (tcnt == half - 4'd1) v0 <= rxd;
      if (tcnt == half) v1 <= rxd;
      case (st)
        IDLE: if (!rxd) begin st <= START; tcnt <= 4'd1; end
        START:
          if (tcnt == half && rxd) st <= IDLE;
          else if (tcnt == last) begin
            st <= DATA; tcnt <= '0; bitn <= '0; xacc <= 1'b0;
          end
        DATA: begin
          if (tcnt == half + 4'd1) begin sh <= {vote, sh[8:1]}; xacc <= xacc ^ vote; end
          if (tcnt == last) begin
            tcnt <= '0;
            bitn <= bitn + 4'd1;
            if (bitn == nbits - 4'd1) st <= pen ? PAR : STOP;
          end
        end
        PAR: begin
          if (tcnt == half + 4'd1) pbit <= vote;
          if (tcnt == last) begin tcnt <= '0; st <= STOP; end
        end
        STOP: if (tcnt == half + 4'd1) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  always_comb begin
    n0 = q0; n1 = q1; ncnt = cnt; nhold = hold; nhv = hold_v;
    if (pop) begin n0 = q1; ncnt = cnt - 2'd1; end
    if (nhv && ncnt < 2'd2) begin
      if (ncnt == 2'd0) n0 = nhold; else n1 = nhold;
      ncnt = ncnt + 2'd1; nhv = 1'b0;
    end
    if (push) begin
      if (ncnt < 2'd2) begin
        if (ncnt == 2'd0) n0 = newe; else n1 = newe;
        ncnt = ncnt + 2'd1;
      end else begin
        nhold = newe; nhv = 1'b1;
      end
    end
    if (ovr_set) begin nhv = 1'b0; n0[11] = 1'b1; end
    if (!rx_en) begin ncnt = 2'd0; nhv = 1'b0; end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q0 <= '0; q1 <= '0; hold <= '0; cnt <= '0; hold_v <= 1'b0;
      dbl <= 1'b0; mpm <= 1'b0; ie_rxc <= 1'b0; ie_txc <= 1'b0; ie_udre <= 1'b0;
      rx_en <= 1'b0; pen <= 1'b0; podd <= 1'b0; size <= '0;
    end else begin
      q0 <= n0; q1 <= n1; hold <= nhold; cnt <= ncnt; hold_v <= nhv;
      if (wr_en)
        case (addr)
          2'd1: {dbl, mpm} <= wdata[1:0];
          2'd2: {ie_rxc, ie_txc, ie_udre, rx_en} <= wdata[7:4];
          2'd3: begin {podd, pen} <= wdata[5:4]; size <= wdata[2:0]; end
          default: ;
        endcase
    end
  end

  always_comb
    case (addr)
      2'd0:    rdata = rxc ? q0[7:0] : 8'h00;
      2'd1:    rdata = {rxc, rxc & q0[8], 1'b0, rxc & q0[9], rxc & q0[11], rxc & q0[10], dbl, mpm};
      2'd2:    rdata = {ie_rxc, ie_txc, ie_udre, rx_en, 4'b0000};
      default: rdata = {2'b00, podd, pen, 1'b0, size};
    endcase

  assign irq_rxc  = gie & ie_rxc & rxc;
  assign irq_txc  = gie & ie_txc & tx_done_i;
  assign irq_udre = gie & ie_udre & tx_empty_i;
endmodule

// File: rtl/serial_rx_buf_chk.sv
module serial_rx_buf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       pop,
  input logic       push,
  input logic       hold_v,
  input logic [1:0] cnt,
  input logic       gie,
  input logic       irq_rxc,
  input logic       irq_txc,
  input logic       irq_udre
);
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= 2'd2);
  // R2
  hold_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n) hold_v |-> cnt == 2'd2);
  // R1
  pop_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && pop && !push && !hold_v |=> cnt == $past(cnt) - 2'd1);
  // R10
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n) !rx_en |=> cnt == 2'd0 && !hold_v);
  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) !gie |-> !irq_rxc && !irq_txc && !irq_udre);
endmodule

bind serial_rx_buf serial_rx_buf_chk i_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .pop(pop), .push(push), .hold_v(hold_v),
  .cnt(cnt), .gie(gie), .irq_rxc(irq_rxc), .irq_txc(irq_txc), .irq_udre(irq_udre)
);

// File: tb/test_serial_rx_buf.sv
module test_serial_rx_buf;
  logic clk = 0, rst_n = 0, rxd = 1, baud_tick = 0, wr_en = 0, rd_en = 0;
  logic gie = 0, tx_done_i = 0, tx_empty_i = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata, s, v, v2;
  logic irq_rxc, irq_txc, irq_udre;
  int n_run = 0, n_fail = 0, cyc = 0, bp = 32;

  serial_rx_buf i_serial_rx_buf (.clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick(baud_tick),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .gie(gie),
    .tx_done_i(tx_done_i), .tx_empty_i(tx_empty_i), .irq_rxc(irq_rxc), .irq_txc(irq_txc),
    .irq_udre(irq_udre));

  always #2 clk = ~clk;
  always @(negedge clk) baud_tick <= ~baud_tick;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog (all R) actual=%0d cycles expected<190000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic idle(input int k);
    repeat (k * bp) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input int n, input bit pe, input bit odd,
                      input bit flip, input bit stopv, input bit glitch);
    logic p;
    p = odd ^ flip;
    for (int i = 0; i < n; i++) p ^= d[i];
    @(negedge clk); rxd = 0; repeat (bp) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxd = d[i];
      if (glitch && i == 0) begin
        repeat (bp / 2 - 1) @(negedge clk); rxd = ~rxd;
        repeat (2) @(negedge clk); rxd = ~rxd;
        repeat (bp / 2 - 1) @(negedge clk);
      end else repeat (bp) @(negedge clk);
    end
    if (pe) begin rxd = p; repeat (bp) @(negedge clk); end
    rxd = stopv; repeat (bp) @(negedge clk);
    rxd = 1;
  endtask

  task automatic setfmt(input int n, input bit pe, input bit odd);
    wr(2'd3, {2'b00, odd, pe, 1'b0, 3'(n - 5)});
  endtask

  task automatic setst(input bit dbl, input bit mpm);
    wr(2'd1, {6'b0, dbl, mpm});
    bp = dbl ? 16 : 32;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    rd(2'd1, s); chk(16'(s), 16'h00, "R1 reset status");
    rd(2'd2, s); chk(16'(s), 16'h00, "R10 reset control");
    rd(2'd3, s); chk(16'(s), 16'h00, "R1 reset format");
    chk(16'({irq_rxc, irq_txc, irq_udre}), 16'h0, "R11 reset irqs");
    wr(2'd2, 8'h10);

    // R1 R3 R7 sweep: length x parity x speed x patterns
    for (int dbl = 0; dbl < 2; dbl++)
      for (int n = 5; n <= 9; n++)
        for (int pm = 0; pm < 3; pm++)
          for (int k = 0; k < 3; k++) begin
            logic [8:0] d, m;
            m = 9'((1 << n) - 1);
            d = (k == 0) ? (9'h155 & m) : (k == 1) ? (9'h0AA & m) : (9'(k * 37 + n * 11 + pm) & m);
            setst(dbl[0], 1'b0); setfmt(n, pm != 0, pm == 2);
            send(d, n, pm != 0, pm == 2, 1'b0, 1'b1, 1'b0);
            idle(1);
            rd(2'd1, s);
            chk(16'(s[7]), 16'h1, "R1 ready flag");
            chk(16'(s[6]), 16'(n == 9 ? d[8] : 1'b0), "R1 ninth bit");
            chk(16'(s[4:2]), 16'h0, "R3 R4 no errors");
            chk(16'(s[1]), 16'(dbl), "R7 speed bit");
            rd(2'd0, v); chk(16'(v), 16'(d[7:0]), "R1 R7 data");
          end
    setst(0, 0); setfmt(8, 1, 0);
    send(9'h05A, 8, 1, 0, 1, 1, 0); idle(1);
    rd(2'd1, s); chk(16'(s[2]), 16'h1, "R3 even parity error");
    rd(2'd0, v);
    setfmt(8, 1, 1);
    send(9'h0C1, 8, 1, 1, 1, 1, 0); idle(1);
    rd(2'd1, s); chk(16'(s[2]), 16'h1, "R3 odd parity error");
    rd(2'd0, v); chk(16'(v), 16'h00C1, "R3 data kept");

    // R4 R5 flags per character
    setfmt(8, 0, 0);
    send(9'h011, 8, 0, 0, 0, 1, 0); idle(1);
    send(9'h022, 8, 0, 0, 0, 0, 0); idle(2);
    rd(2'd1, s); chk(16'(s[4]), 16'h0, "R4 R5 first clean");
    rd(2'd0, v); chk(16'(v), 16'h0011, "R5 first data");
    rd(2'd1, s); chk(16'(s[4]), 16'h1, "R4 R5 second framing");
    rd(2'd0, v); chk(16'(v), 16'h0022, "R5 second data");

    // R2 three characters, no overrun
    send(9'h0A1, 8, 0, 0, 0, 1, 0); send(9'h0A2, 8, 0, 0, 0, 1, 0);
    send(9'h0A3, 8, 0, 0, 0, 1, 0); idle(1);
    rd(2'd1, s); chk(16'(s[3]), 16'h0, "R2 no overrun");
    rd(2'd0, v); chk(16'(v), 16'h00A1, "R2 order 1");
    rd(2'd0, v); chk(16'(v), 16'h00A2, "R2 order 2");
    rd(2'd0, v); chk(16'(v), 16'h00A3, "R2 held moves in");
    rd(2'd1, s); chk(16'(s[7]), 16'h0, "R2 empty");

    // R6 overrun
    send(9'h0B1, 8, 0, 0, 0, 1, 0); send(9'h0B2, 8, 0, 0, 0, 1, 0);
    send(9'h0B3, 8, 0, 0, 0, 1, 0); send(9'h0B4, 8, 0, 0, 0, 1, 0); idle(1);
    rd(2'd1, s); chk(16'(s[3]), 16'h1, "R6 overrun flag");
    rd(2'd0, v); chk(16'(v), 16'h00B1, "R6 kept 1");
    rd(2'd1, s); chk(16'(s[3]), 16'h0, "R6 R5 flag advances");
    rd(2'd0, v); chk(16'(v), 16'h00B2, "R6 kept 2");
    rd(2'd0, v); chk(16'(v), 16'h00B4, "R6 newest after drop");
    rd(2'd1, s); chk(16'(s[7]), 16'h0, "R6 empty");

    // R2 pop and push across every offset of the stop bit
    for (int off = 0; off < bp; off++) begin
      send(9'h03C, 8, 0, 0, 0, 1, 0); idle(1);
      fork
        send(9'h0C3, 8, 0, 0, 0, 1, 0);
        begin repeat (9 * bp + 1 + off) @(negedge clk); rd(2'd0, v2); end
      join
      chk(16'(v2), 16'h003C, "R2 coincident pop");
      idle(1);
      rd(2'd0, v); chk(16'(v), 16'h00C3, "R2 coincident push");
      rd(2'd1, s); chk(16'(s[7]), 16'h0, "R2 coincident empty");
    end

    // R8 false start and glitch
    @(negedge clk); rxd = 0; repeat (6) @(negedge clk); rxd = 1; idle(2);
    rd(2'd1, s); chk(16'(s[7]), 16'h0, "R8 false start ignored");
    send(9'h0F0, 8, 0, 0, 0, 1, 1); idle(1);
    rd(2'd0, v); chk(16'(v), 16'h00F0, "R8 glitch outvoted");

    // R9 multi-drop filter
    setst(0, 1); setfmt(9, 0, 0);
    rd(2'd1, s); chk(16'(s[0]), 16'h1, "R9 mode bit");
    send(9'h055, 9, 0, 0, 0, 1, 0); idle(1);
    rd(2'd1, s); chk(16'(s[7]), 16'h0, "R9 data frame dropped");
    send(9'h1A5, 9, 0, 0, 0, 1, 0); idle(1);
    rd(2'd1, s); chk(16'({s[7], s[6]}), 16'h3, "R9 address accepted");
    rd(2'd0, v); chk(16'(v), 16'h00A5, "R9 address data");
    setfmt(8, 0, 0);
    send(9'h077, 8, 0, 0, 0, 0, 0); idle(2);
    rd(2'd1, s); chk(16'(s[7]), 16'h0, "R9 stop indicator 0 dropped");
    send(9'h066, 8, 0, 0, 0, 1, 0); idle(1);
    rd(2'd0, v); chk(16'(v), 16'h0066, "R9 stop indicator 1 kept");
    setst(0, 0);

    // R12 status writes, R10 disable
    send(9'h044, 8, 0, 0, 0, 0, 0); idle(2);
    wr(2'd1, 8'h1C);
    rd(2'd1, s); chk(16'({s[7], s[4:0]}), 16'h30, "R12 error bits unchanged");
    wr(2'd1, 8'h1E);
    rd(2'd1, s); chk(16'({s[4:0]}), 16'h12, "R12 speed bit writable");
    setst(0, 0);
    wr(2'd2, 8'h00);
    rd(2'd1, s); chk(16'({s[7], s[4:2]}), 16'h0, "R10 flush");
    send(9'h099, 8, 0, 0, 0, 1, 0); idle(1);
    wr(2'd2, 8'h10);
    rd(2'd1, s); chk(16'(s[7]), 16'h0, "R10 ignored while off");

    // R11 interrupt gating, exhaustive
    for (int f = 0; f < 2; f++) begin
      if (f == 1) begin send(9'h012, 8, 0, 0, 0, 1, 0); idle(1); end
      for (int k = 0; k < 64; k++) begin
        logic [2:0] ie;
        logic [2:0] e;
        ie = 3'(k);
        wr(2'd2, {ie, 1'b1, 4'b0000});
        gie = k[3]; tx_done_i = k[4]; tx_empty_i = k[5];
        @(negedge clk);
        e = {k[3] & ie[2] & f[0], k[3] & ie[1] & k[4], k[3] & ie[0] & k[5]};
        chk(16'({irq_rxc, irq_txc, irq_udre}), 16'(e), "R11 irq gating");
      end
    end
    gie = 0;
    rd(2'd0, v); chk(16'(v), 16'h0012, "R11 R1 data");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule